// File: doc/BRIEF.md
# Address Bank Router with Unmapped-Access Interrupt

This block sits between a CPU's 16-bit memory port and the memory-mapped devices around it. It splits the address into a 5-bit bank number (bits 15:11) and an 11-bit offset inside a 2 KB bank. During a memory command it asserts one chip select for the addressed bank, and only if that bank is populated. The populated banks are general RAM, an I/O page, font RAM, text RAM and video RAM. The router also holds a small I/O page with an LED output register and a switch input. It steers read data back to the CPU in a fixed priority order.

A command that lands in an unpopulated bank selects nothing. The router records the upper address byte and raises an interrupt request. The request carries an event word: a tag byte of 0x80 followed by the captured byte. The request stays up until the CPU acknowledges it. The notifier then spends two recovery cycles before it can accept another fault, so each separate bad access after recovery raises its own interrupt.

Top module: `bank_select_unit`

## Requirements
- R1: `bank_cs` bit b is high only while `cmd` is high and `addr[15:11]` equals b, and only for populated banks. The populated banks are 0 to 7 (RAM, 0x0000 to 0x3FFF), 18 (I/O, 0x9000 to 0x97FF), 20 and 21 (font RAM), 22 and 23 (text RAM), and 24 to 29 (video RAM, 0xC000 to 0xEFFF). At most one bit is high at a time.
- R2: `bank_off` always equals `addr & 0x07FF`.
- R3: `rdata` follows a fixed priority. While `int_ack` is high it is `int_event`. Otherwise, if a bank other than the I/O bank is selected, it is `mem_rdata`. Otherwise it is the I/O read value.
- R4: A command with `we` high at address 0x9000 loads `leds` from `wdata[7:0]`, visible after the next clock edge. Writes to other addresses leave `leds` unchanged.
- R5: The I/O read value is `{8'h00, switches}` when `addr` is 0x9001 and zero at every other address.
- R6: A command start at an unpopulated bank, with the notifier idle, sets `int_req` after the second rising edge. At the same time `int_event` becomes `{8'h80, addr[15:8]}`.
- R7: `int_req` stays high until a clock edge that samples `int_ack` high. It is low after that edge.
- R8: For the two cycles after the request drops, the notifier is recovering and ignores new faults. After recovery, a new unpopulated access fires a new interrupt with its own event word.
- R9: A command held high over several cycles counts as one access and produces at most one interrupt.
- R10: While `rst_n` is low and right after it is released, `leds`, `int_req` and `int_event` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 1 | Memory command active |
| we | input | 1 | Command is a write |
| addr | input | 16 | CPU address |
| wdata | input | 16 | CPU write data |
| mem_rdata | input | 16 | Read data from the selected memory bank |
| switches | input | 8 | Switch inputs |
| int_ack | input | 1 | Interrupt acknowledge from the CPU |
| rdata | output | 16 | Read data to the CPU |
| bank_cs | output | 32 | One chip select per bank |
| bank_off | output | 11 | Offset within the bank |
| leds | output | 8 | LED register |
| int_req | output | 1 | Interrupt request |
| int_event | output | 16 | Interrupt event word |

## Verification
The hardest situations to reach from the ports are a fault that arrives while the notifier is still recovering, and a fault held across many cycles. Random traffic almost never lines up with the two-cycle recovery window. Directed steps therefore acknowledge an interrupt and then issue an unpopulated access on the very next cycle. The test expects no interrupt from that access, and then expects a fresh interrupt from a later access once the notifier is idle. A separate step keeps `cmd` high on an unpopulated bank across the acknowledge and recovery cycles, to show that no second request appears.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BANK_W = 5;
  localparam int OFF_W  = ADDR_W - BANK_W;
  localparam int NBANKS = 1 << BANK_W;
  localparam int TAG_W  = 8;

  localparam logic [TAG_W-1:0] EVT_TAG = 8'h80;

  localparam int RAM_LO  = 0;
  localparam int RAM_HI  = 7;
  localparam int IO_BANK = 18;
  localparam int FNT_LO  = 20;
  localparam int FNT_HI  = 21;
  localparam int TXT_LO  = 22;
  localparam int TXT_HI  = 23;
  localparam int VID_LO  = 24;
  localparam int VID_HI  = 29;

  localparam logic [ADDR_W-1:0] LED_ADDR = 16'h9000;
  localparam logic [ADDR_W-1:0] SW_ADDR  = 16'h9001;

  typedef enum logic [1:0] {
    NT_IDLE = 2'd0,
    NT_WAIT = 2'd1,
    NT_REC1 = 2'd2,
    NT_REC2 = 2'd3
  } notif_state_t;

  function automatic bit bank_populated(input int b);
    return (b >= RAM_LO && b <= RAM_HI) || (b == IO_BANK) ||
           (b >= FNT_LO && b <= FNT_HI) || (b >= TXT_LO && b <= TXT_HI) ||
           (b >= VID_LO && b <= VID_HI);
  endfunction
endpackage

// File: rtl/bank_addr_decode.sv
module bank_addr_decode #(
  parameter int ADDR_W = bsu_pkg::ADDR_W,
  parameter int BANK_W = bsu_pkg::BANK_W,
  localparam int OFF_W  = ADDR_W - BANK_W,
  localparam int NBANKS = 1 << BANK_W
) (
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANKS-1:0] cs,
  output logic [OFF_W-1:0]  off,
  output logic              any_cs
);
  logic [BANK_W-1:0] bank_id;

  assign bank_id = addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];

  for (genvar g = 0; g < NBANKS; g++) begin : g_cs
    if (bsu_pkg::bank_populated(g)) begin : g_pop
      assign cs[g] = cmd && (bank_id == BANK_W'(g));
    end else begin : g_hole
      assign cs[g] = 1'b0;
    end
  end

  assign any_cs = |cs;
endmodule

// File: rtl/bank_io_regs.sv
module bank_io_regs #(
  parameter int ADDR_W = bsu_pkg::ADDR_W,
  parameter int DATA_W = bsu_pkg::DATA_W,
  parameter int LED_W  = 8,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LED_W-1:0]  wdata_lo,
  input  logic [SW_W-1:0]   switches,
  output logic [LED_W-1:0]  leds,
  output logic [DATA_W-1:0] io_rdata
);
  logic             led_en;
  logic [LED_W-1:0] led_d;
  logic [LED_W-1:0] led_q;

  always_comb begin
    led_en = cmd && we && (addr == bsu_pkg::LED_ADDR);
    led_d  = led_en ? wdata_lo : led_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= '0;
    else        led_q <= led_d;
  end

  always_comb begin
    if (addr == bsu_pkg::SW_ADDR) io_rdata = DATA_W'(switches);
    else                          io_rdata = '0;
  end

  assign leds = led_q;
endmodule

// File: rtl/bank_err_detect.sv
module bank_err_detect #(
  parameter int TAG_W = bsu_pkg::TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd,
  input  logic             any_cs,
  input  logic [TAG_W-1:0] addr_hi,
  output logic             err_pulse,
  output logic [TAG_W-1:0] err_byte
);
  logic             cmd_q;
  logic             err_d, err_q;
  logic [TAG_W-1:0] byte_d, byte_q;

  always_comb begin
    err_d  = cmd && !cmd_q && !any_cs;
    byte_d = err_d ? addr_hi : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      err_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      cmd_q  <= cmd;
      err_q  <= err_d;
      byte_q <= byte_d;
    end
  end

  assign err_pulse = err_q;
  assign err_byte  = byte_q;
endmodule

// File: rtl/bank_irq_notifier.sv
module bank_irq_notifier #(
  parameter int TAG_W  = bsu_pkg::TAG_W,
  parameter int DATA_W = bsu_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_pulse,
  input  logic [TAG_W-1:0]  err_byte,
  input  logic              ack,
  output logic              req,
  output logic [DATA_W-1:0] evt
);
  import bsu_pkg::*;

  notif_state_t      st_q, st_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] evt_q, evt_d;

  always_comb begin
    st_d  = st_q;
    req_d = req_q;
    evt_d = evt_q;
    unique case (st_q)
      NT_IDLE: if (err_pulse) begin
        req_d = 1'b1;
        evt_d = DATA_W'({EVT_TAG, err_byte});
        st_d  = NT_WAIT;
      end
      NT_WAIT: if (req_q && ack) begin
        req_d = 1'b0;
        st_d  = NT_REC1;
      end
      NT_REC1: st_d = NT_REC2;
      NT_REC2: st_d = NT_IDLE;
      default: st_d = NT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= NT_IDLE;
      req_q <= 1'b0;
      evt_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      evt_q <= evt_d;
    end
  end

  assign req = req_q;
  assign evt = evt_q;
endmodule

// File: rtl/bank_select_unit.sv
module bank_select_unit #(
  parameter int ADDR_W = bsu_pkg::ADDR_W,
  parameter int DATA_W = bsu_pkg::DATA_W,
  parameter int BANK_W = bsu_pkg::BANK_W,
  parameter int LED_W  = 8,
  parameter int SW_W   = 8,
  localparam int OFF_W  = ADDR_W - BANK_W,
  localparam int NBANKS = 1 << BANK_W,
  localparam int TAG_W  = bsu_pkg::TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [SW_W-1:0]   switches,
  input  logic              int_ack,
  output logic [DATA_W-1:0] rdata,
  output logic [NBANKS-1:0] bank_cs,
  output logic [OFF_W-1:0]  bank_off,
  output logic [LED_W-1:0]  leds,
  output logic              int_req,
  output logic [DATA_W-1:0] int_event
);
  logic              any_cs;
  logic              err_pulse;
  logic [TAG_W-1:0]  err_byte;
  logic [DATA_W-1:0] io_rdata;
  logic              mem_sel;

  bank_addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
    .cmd(cmd), .addr(addr), .cs(bank_cs), .off(bank_off), .any_cs(any_cs)
  );

  bank_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W)) u_io (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .we(we), .addr(addr),
    .wdata_lo(wdata[LED_W-1:0]), .switches(switches), .leds(leds), .io_rdata(io_rdata)
  );

  bank_err_detect #(.TAG_W(TAG_W)) u_err (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .any_cs(any_cs),
    .addr_hi(addr[ADDR_W-1:ADDR_W-TAG_W]), .err_pulse(err_pulse), .err_byte(err_byte)
  );

  bank_irq_notifier #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_byte(err_byte),
    .ack(int_ack), .req(int_req), .evt(int_event)
  );

  always_comb begin
    mem_sel = 1'b0;
    for (int b = 0; b < NBANKS; b++) begin
      if (b != bsu_pkg::IO_BANK && bank_cs[b]) mem_sel = 1'b1;
    end
  end

  always_comb begin
    if (int_ack)      rdata = int_event;
    else if (mem_sel) rdata = mem_rdata;
    else              rdata = io_rdata;
  end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd,
  input logic        we,
  input logic [15:0] addr,
  input logic [15:0] wdata,
  input logic        int_ack,
  input logic [31:0] bank_cs,
  input logic [7:0]  leds,
  input logic        int_req,
  input logic [15:0] int_event
);
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs));
  assert_cs_needs_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |-> (bank_cs == 32'd0));
  assert_led_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && we && addr == 16'h9000) |=> (leds == $past(wdata[7:0])));
  assert_event_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> (int_event[15:8] == 8'h80));
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> int_req);
  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> !int_req);
  assert_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_req) |=> !int_req ##1 !int_req);
endmodule

bind bank_select_unit bsu_checker u_chk (.*);

// File: tb/sim_bank_select_unit.sv
module sim_bank_select_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd, we, int_ack;
  logic [15:0] addr, wdata, mem_rdata;
  logic [7:0]  switches;
  logic [15:0] rdata;
  logic [31:0] bank_cs;
  logic [10:0] bank_off;
  logic [7:0]  leds;
  logic        int_req;
  logic [15:0] int_event;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_led;

  bank_select_unit u0 (.*);

  always #4 clk = ~clk;

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit populated(input int b);
    return (b <= 7) || (b == 18) || (b >= 20 && b <= 29);
  endfunction

  function automatic logic [31:0] exp_cs(input logic c, input logic [15:0] a);
    int b = int'(a[15:11]);
    if (c && populated(b)) return 32'd1 << b;
    return 32'd0;
  endfunction

  function automatic logic [15:0] exp_rd(input logic c, input logic [15:0] a,
                                         input logic [15:0] m, input logic [7:0] s);
    int b = int'(a[15:11]);
    if (c && populated(b) && b != 18) return m;
    if (a == 16'h9001) return {8'h00, s};
    return 16'h0000;
  endfunction

  initial begin
    rst_n = 1'b0; cmd = 0; we = 0; int_ack = 0;
    addr = 0; wdata = 0; mem_rdata = 16'hBEEF; switches = 8'hA5;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R10 leds in reset", leds, 0);
    chk("R10 req in reset", int_req, 0);
    rst_n = 1'b1;
    step();
    chk("R10 leds after reset", leds, 0);
    chk("R10 req after reset", int_req, 0);
    chk("R10 event after reset", int_event, 0);
    exp_led = 8'h00;

    // R4 LED write, and a write elsewhere leaves it alone
    cmd = 1; we = 1; addr = 16'h9000; wdata = 16'h1234;
    step();
    chk("R4 led load", leds, 8'h34);
    addr = 16'h9002; wdata = 16'h00FF;
    step();
    chk("R4 other io write ignored", leds, 8'h34);
    exp_led = 8'h34;
    we = 0;

    // R5 switch read, R3 io path
    addr = 16'h9001; #1;
    chk("R5 switch read", rdata, 16'h00A5);
    chk("R1 io bank select", bank_cs, 32'd1 << 18);
    addr = 16'h9004; #1;
    chk("R5 other io reads zero", rdata, 0);
    addr = 16'hB7FF; #1;
    chk("R3 text ram data", rdata, 16'hBEEF);
    chk("R2 offset", bank_off, 11'h7FF);
    cmd = 0;
    step();

    // R6 fault raises interrupt two edges later
    cmd = 1; addr = 16'h5123;
    step();
    chk("R6 not yet after one edge", int_req, 0);
    cmd = 0;
    step();
    chk("R6 req raised", int_req, 1);
    chk("R6 event word", int_event, 16'h8051);
    repeat (3) step();
    chk("R7 req held without ack", int_req, 1);
    int_ack = 1; cmd = 1; addr = 16'h0010; #1;
    chk("R3 ack has priority", rdata, 16'h8051);
    cmd = 0;
    step();
    chk("R7 req dropped by ack", int_req, 0);
    int_ack = 0;
    // R8 fault during recovery is ignored
    cmd = 1; addr = 16'hF800;
    step();
    cmd = 0;
    step(); step();
    chk("R8 fault in recovery ignored", int_req, 0);
    chk("R8 event kept", int_event, 16'h8051);
    // R8 refire after recovery
    cmd = 1; addr = 16'h4800;
    step();
    cmd = 0;
    step();
    chk("R8 refire req", int_req, 1);
    chk("R8 refire event", int_event, 16'h8048);
    int_ack = 1; step(); int_ack = 0;
    step(); step(); step();

    // R9 held command yields one interrupt
    cmd = 1; addr = 16'hF0AB;
    step(); step();
    chk("R9 held cmd fires", int_req, 1);
    chk("R9 event", int_event, 16'h80F0);
    int_ack = 1; step(); int_ack = 0;
    repeat (5) step();
    chk("R9 held cmd no second interrupt", int_req, 0);
    cmd = 0;
    step();

    // random traffic: R1 R2 R3 R4 R5
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = $urandom;
      if (i % 16 == 3) a = 16'h9000;
      if (i % 16 == 7) a = 16'h9001;
      addr = a; cmd = $urandom % 2; we = $urandom % 2;
      wdata = $urandom; mem_rdata = $urandom; switches = $urandom;
      #1;
      chk("R1 random cs", bank_cs, exp_cs(cmd, addr));
      chk("R2 random offset", bank_off, addr & 16'h07FF);
      chk("R3 random rdata", rdata, exp_rd(cmd, addr, mem_rdata, switches));
      if (cmd && we && addr == 16'h9000) exp_led = wdata[7:0];
      step();
      chk("R4 random leds", leds, exp_led);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule